// File: doc/BRIEF.md
# Translation Cache with Access Checks

This block turns the virtual addresses of loads and stores into physical addresses. It holds a small, fully associative set of page translations for a 48-bit virtual space with 4 KB pages. The low 12 address bits pass through unchanged, and the cached frame number replaces the virtual page number. Each lookup is checked against the user/kernel mode of the access and against the entry's permission flags. The response carries the physical address, a flag that tells the memory path to bypass caching, and an exception code.

When a page is not held in the cache, the block asks an external table walker for the entry and installs the result. It does not write referenced and modified status to the page table on every access. It keeps that status in the cached entry and marks the entry as changed. The status goes out on a write-back port only when a changed entry is displaced or flushed. Software-driven commands either discard translations silently (invalidate) or write back their changed status first (flush). Each command acts on one page or on the whole cache.

Top module: `tlb_xlate`

## Requirements
- R1: An access that passes all checks responds with `rsp_pa = {frame number, req_va[11:0]}`, `rsp_exc = 0`, and `rsp_nocache` equal to the entry's cache-disable flag. The response comes one cycle after the request on a hit.
- R2: A walker answer with `walk_present = 0` gives `rsp_exc = 1` (page fault), with `rsp_pa = 0` and `rsp_nocache = 0`. Nothing is installed, so the next access to that page misses again.
- R3: A user-mode access (`req_user = 1`) to an entry with the kernel flag set gives `rsp_exc = 2` (privilege).
- R4: A store (`req_store = 1`) to a write-protected entry gives `rsp_exc = 3` (write protection). A load to the same entry succeeds.
- R5: When several faults apply, page fault wins over privilege, and privilege wins over write protection. An access that raises any exception leaves the entry's status untouched.
- R6: A successful access sets the entry's referenced bit, and a successful store also sets its modified bit. No status leaves the block on a hit.
- R7: On a miss, `walk_req` pulses for one cycle with `walk_vpn` holding the page number, and `busy` stays high. The response is registered on the cycle `walk_done` is sampled, and a present entry is installed then.
- R8: An install takes the lowest-numbered empty slot. If every slot is valid, it takes the slot named by a round-robin pointer, which then advances. Displacing a changed entry pulses `wb_valid` with its page number and its referenced and modified bits in the same cycle as the response. Displacing an unchanged entry is silent.
- R9: Command codes are `cmd_op = 0` (invalidate one page) and `cmd_op = 1` (invalidate all). An invalidate discards every matching entry and never pulses `wb_valid`.
- R10: Command codes are `cmd_op = 2` (flush one page) and `cmd_op = 3` (flush all). A flush pulses `wb_valid` once for each matching changed entry, then discards it. A command visits one slot per cycle.
- R11: While `busy` is high, requests and commands are ignored. When a command and a request arrive in the same idle cycle, the command is taken and the request is dropped.
- R12: After reset the cache is empty and `rsp_valid`, `walk_req`, `wb_valid` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request strobe |
| req_store | input | 1 | 1 = store, 0 = load |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| req_va | input | VA_W | Virtual address |
| rsp_valid | output | 1 | Response strobe |
| rsp_pa | output | PA_W | Physical address (0 on exception) |
| rsp_nocache | output | 1 | Bypass-caching flag of the translation |
| rsp_exc | output | 2 | 0 none, 1 page fault, 2 privilege, 3 write protection |
| busy | output | 1 | Walk or command in progress |
| walk_req | output | 1 | One-cycle request to the table walker |
| walk_vpn | output | VA_W-PAGE_BITS | Page number to walk |
| walk_done | input | 1 | Walker answer strobe |
| walk_pfn | input | PA_W-PAGE_BITS | Frame number from the walker |
| walk_present | input | 1 | Entry present flag |
| walk_kernel | input | 1 | Kernel-only flag |
| walk_wprot | input | 1 | Write-protect flag |
| walk_nocache | input | 1 | Cache-disable flag |
| cmd_valid | input | 1 | Maintenance command strobe |
| cmd_op | input | 2 | bit1 = flush, bit0 = all entries |
| cmd_va | input | VA_W | Address naming the page for single-page commands |
| wb_valid | output | 1 | Status write-back strobe |
| wb_vpn | output | VA_W-PAGE_BITS | Page whose status is written back |
| wb_ref | output | 1 | Referenced bit written back |
| wb_mod | output | 1 | Modified bit written back |

## Verification
The bench builds the block with two slots and a 32-bit physical address; the virtual address stays 48 bits. Two slots fill after two misses, so the round-robin victim, displacement of both changed and unchanged entries, and the return of a freed slot to first-free selection all show up within a short scripted sequence. With only two slots, a global command finishes in two visits, so every write-back pulse of a flush can be attributed to one known slot.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    EXC_NONE   = 2'd0,
    EXC_PFAULT = 2'd1,
    EXC_PRIV   = 2'd2,
    EXC_WPROT  = 2'd3
  } exc_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_SCAN = 2'd2
  } state_e;

  // Ordered permission check: missing page, then mode, then write protection.
  function automatic exc_e perm_check(input logic present, input logic kernel,
                                      input logic wprot, input logic user,
                                      input logic store);
    if (!present)             return EXC_PFAULT;
    else if (kernel && user)  return EXC_PRIV;
    else if (wprot && store)  return EXC_WPROT;
    else                      return EXC_NONE;
  endfunction

  // New {referenced, modified, changed} after a successful access.
  function automatic logic [2:0] touch(input logic r, input logic m,
                                       input logic c, input logic store);
    return {1'b1, m | store, c | ~r | (store & ~m)};
  endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 36,
  parameter int IDX_W   = 3
) (
  input  logic [ENTRIES-1:0] valid,
  input  logic [VPN_W-1:0]   tags [ENTRIES],
  input  logic [VPN_W-1:0]   vpn,
  output logic [ENTRIES-1:0] hit_vec,
  output logic               hit,
  output logic [IDX_W-1:0]   hit_idx
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = valid[g] && (tags[g] == vpn);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (hit_vec[i]) hit_idx = IDX_W'(i);
  end

  assign hit = |hit_vec;

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid,
  input  logic               take,
  output logic [IDX_W-1:0]   victim_idx,
  output logic               all_full
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!valid[i]) free_idx = IDX_W'(i);
  end

  assign all_full   = &valid;
  assign victim_idx = all_full ? rr_q : free_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rr_q <= '0;
    else if (take && all_full) rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
  end

  assert_rr_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rr_q <= LAST);

  // A victim taken from an empty slot never uses the pointer.
  assert_free_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !all_full) |=> $stable(rr_q));

endmodule

// File: rtl/tlb_resp.sv
module tlb_resp
  import tlb_pkg::*;
#(
  parameter int PFN_W     = 28,
  parameter int PAGE_BITS = 12
) (
  input  logic                       present,
  input  logic                       kernel,
  input  logic                       wprot,
  input  logic                       nocache,
  input  logic                       user,
  input  logic                       store,
  input  logic [PFN_W-1:0]           pfn,
  input  logic [PAGE_BITS-1:0]       ofs,
  output logic [1:0]                 exc,
  output logic                       ok,
  output logic [PFN_W+PAGE_BITS-1:0] pa,
  output logic                       nc_out
);

  exc_e code;

  assign code   = perm_check(present, kernel, wprot, user, store);
  assign exc    = code;
  assign ok     = (code == EXC_NONE);
  assign pa     = ok ? {pfn, ofs} : '0;
  assign nc_out = ok & nocache;

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int VA_W      = 48,
  parameter int PA_W      = 40,
  parameter int PAGE_BITS = 12,
  parameter int ENTRIES   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic                      req_store,
  input  logic                      req_user,
  input  logic [VA_W-1:0]           req_va,
  output logic                      rsp_valid,
  output logic [PA_W-1:0]           rsp_pa,
  output logic                      rsp_nocache,
  output logic [1:0]                rsp_exc,
  output logic                      busy,
  output logic                      walk_req,
  output logic [VA_W-PAGE_BITS-1:0] walk_vpn,
  input  logic                      walk_done,
  input  logic [PA_W-PAGE_BITS-1:0] walk_pfn,
  input  logic                      walk_present,
  input  logic                      walk_kernel,
  input  logic                      walk_wprot,
  input  logic                      walk_nocache,
  input  logic                      cmd_valid,
  input  logic [1:0]                cmd_op,
  input  logic [VA_W-1:0]           cmd_va,
  output logic                      wb_valid,
  output logic [VA_W-PAGE_BITS-1:0] wb_vpn,
  output logic                      wb_ref,
  output logic                      wb_mod
);

  localparam int VPN_W = VA_W - PAGE_BITS;
  localparam int PFN_W = PA_W - PAGE_BITS;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  // Entry storage
  logic [ENTRIES-1:0] v_q, k_q, wp_q, nc_q, r_q, m_q, c_q;
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q [ENTRIES];

  state_e st;
  logic [VPN_W-1:0]     hold_vpn;
  logic [PAGE_BITS-1:0] hold_ofs;
  logic                 hold_store, hold_user;
  logic [VPN_W-1:0]     cmd_vpn_q;
  logic                 cmd_all_q, cmd_flush_q;
  logic [IDX_W-1:0]     scan_idx;

  // Lookup
  logic [VPN_W-1:0]   req_vpn;
  logic [ENTRIES-1:0] hit_vec;
  logic               hit;
  logic [IDX_W-1:0]   hit_idx;

  assign req_vpn = req_va[VA_W-1:PAGE_BITS];

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_match (
    .valid(v_q), .tags(tag_q), .vpn(req_vpn),
    .hit_vec(hit_vec), .hit(hit), .hit_idx(hit_idx)
  );

  // Named events
  logic acc_fire, cmd_fire, hit_fire, miss_fire, fill_fire, install_fire;
  logic scan_sel, scan_wb, evict_wb, acc_ok;

  assign cmd_fire     = (st == ST_IDLE) && cmd_valid;
  assign acc_fire     = (st == ST_IDLE) && req_valid && !cmd_valid;
  assign hit_fire     = acc_fire && hit;
  assign miss_fire    = acc_fire && !hit;
  assign fill_fire    = (st == ST_WALK) && walk_done;
  assign install_fire = fill_fire && walk_present;

  // Victim choice
  logic [IDX_W-1:0] vic_idx;
  logic             vic_full;

  tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk(clk), .rst_n(rst_n), .valid(v_q), .take(install_fire),
    .victim_idx(vic_idx), .all_full(vic_full)
  );

  assign evict_wb = install_fire && v_q[vic_idx] && c_q[vic_idx];
  assign scan_sel = (st == ST_SCAN) && v_q[scan_idx] &&
                    (cmd_all_q || (tag_q[scan_idx] == cmd_vpn_q));
  assign scan_wb  = scan_sel && cmd_flush_q && c_q[scan_idx];

  // Shared response path: cached entry on a hit, walker data on a fill
  logic                 in_walk;
  logic [1:0]           r_exc;
  logic [PA_W-1:0]      r_pa;
  logic                 r_nc;
  logic                 cur_store, cur_user;

  assign in_walk   = (st == ST_WALK);
  assign cur_store = in_walk ? hold_store : req_store;
  assign cur_user  = in_walk ? hold_user  : req_user;

  tlb_resp #(.PFN_W(PFN_W), .PAGE_BITS(PAGE_BITS)) u_resp (
    .present (in_walk ? walk_present : 1'b1),
    .kernel  (in_walk ? walk_kernel  : k_q[hit_idx]),
    .wprot   (in_walk ? walk_wprot   : wp_q[hit_idx]),
    .nocache (in_walk ? walk_nocache : nc_q[hit_idx]),
    .user    (cur_user),
    .store   (cur_store),
    .pfn     (in_walk ? walk_pfn : pfn_q[hit_idx]),
    .ofs     (in_walk ? hold_ofs : req_va[PAGE_BITS-1:0]),
    .exc     (r_exc),
    .ok      (acc_ok),
    .pa      (r_pa),
    .nc_out  (r_nc)
  );

  assign busy     = (st != ST_IDLE);
  assign walk_vpn = hold_vpn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      v_q         <= '0;
      k_q         <= '0;
      wp_q        <= '0;
      nc_q        <= '0;
      r_q         <= '0;
      m_q         <= '0;
      c_q         <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0;
        pfn_q[i] <= '0;
      end
      hold_vpn    <= '0;
      hold_ofs    <= '0;
      hold_store  <= 1'b0;
      hold_user   <= 1'b0;
      cmd_vpn_q   <= '0;
      cmd_all_q   <= 1'b0;
      cmd_flush_q <= 1'b0;
      scan_idx    <= '0;
      rsp_valid   <= 1'b0;
      rsp_pa      <= '0;
      rsp_nocache <= 1'b0;
      rsp_exc     <= '0;
      walk_req    <= 1'b0;
      wb_valid    <= 1'b0;
      wb_vpn      <= '0;
      wb_ref      <= 1'b0;
      wb_mod      <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      walk_req  <= 1'b0;
      wb_valid  <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (cmd_fire) begin
            st          <= ST_SCAN;
            scan_idx    <= '0;
            cmd_vpn_q   <= cmd_va[VA_W-1:PAGE_BITS];
            cmd_all_q   <= cmd_op[0];
            cmd_flush_q <= cmd_op[1];
          end else if (hit_fire) begin
            rsp_valid   <= 1'b1;
            rsp_pa      <= r_pa;
            rsp_nocache <= r_nc;
            rsp_exc     <= r_exc;
            if (acc_ok)
              {r_q[hit_idx], m_q[hit_idx], c_q[hit_idx]} <=
                touch(r_q[hit_idx], m_q[hit_idx], c_q[hit_idx], req_store);
          end else if (miss_fire) begin
            walk_req   <= 1'b1;
            hold_vpn   <= req_vpn;
            hold_ofs   <= req_va[PAGE_BITS-1:0];
            hold_store <= req_store;
            hold_user  <= req_user;
            st         <= ST_WALK;
          end
        end
        ST_WALK: begin
          if (fill_fire) begin
            st          <= ST_IDLE;
            rsp_valid   <= 1'b1;
            rsp_pa      <= r_pa;
            rsp_nocache <= r_nc;
            rsp_exc     <= r_exc;
            if (evict_wb) begin
              wb_valid <= 1'b1;
              wb_vpn   <= tag_q[vic_idx];
              wb_ref   <= r_q[vic_idx];
              wb_mod   <= m_q[vic_idx];
            end
            if (install_fire) begin
              v_q[vic_idx]   <= 1'b1;
              tag_q[vic_idx] <= hold_vpn;
              pfn_q[vic_idx] <= walk_pfn;
              k_q[vic_idx]   <= walk_kernel;
              wp_q[vic_idx]  <= walk_wprot;
              nc_q[vic_idx]  <= walk_nocache;
              r_q[vic_idx]   <= acc_ok;
              m_q[vic_idx]   <= acc_ok & hold_store;
              c_q[vic_idx]   <= acc_ok;
            end
          end
        end
        ST_SCAN: begin
          if (scan_sel) begin
            v_q[scan_idx] <= 1'b0;
            c_q[scan_idx] <= 1'b0;
          end
          if (scan_wb) begin
            wb_valid <= 1'b1;
            wb_vpn   <= tag_q[scan_idx];
            wb_ref   <= r_q[scan_idx];
            wb_mod   <= m_q[scan_idx];
          end
          if (scan_idx == LAST) st <= ST_IDLE;
          else                  scan_idx <= scan_idx + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // Assertions
  assert_pf_no_pa_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_exc == EXC_PFAULT) |-> (rsp_pa == '0 && !rsp_nocache));

  assert_walk_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req |=> !walk_req);

  assert_walk_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req |-> busy);

  assert_no_wb_on_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(st) != ST_IDLE);

  assert_inv_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && $past(st) == ST_SCAN) |-> $past(cmd_flush_q));

  assert_single_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  assert_rsp_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !busy);

  assert_no_status_on_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_fire && !acc_ok) |=> ($stable(r_q) && $stable(m_q) && $stable(c_q)));

endmodule

// File: tb/test_tlb_xlate.sv
module test_tlb_xlate;

  localparam int VA_W = 48;
  localparam int PA_W = 32;
  localparam int PB   = 12;
  localparam int VPNW = VA_W - PB;
  localparam int PFNW = PA_W - PB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic            req_valid = 0, req_store = 0, req_user = 0;
  logic [VA_W-1:0] req_va = '0;
  logic            rsp_valid, rsp_nocache, busy, walk_req;
  logic [PA_W-1:0] rsp_pa;
  logic [1:0]      rsp_exc;
  logic [VPNW-1:0] walk_vpn, wb_vpn;
  logic            walk_done = 0, walk_present = 0, walk_kernel = 0;
  logic            walk_wprot = 0, walk_nocache = 0;
  logic [PFNW-1:0] walk_pfn = '0;
  logic            cmd_valid = 0;
  logic [1:0]      cmd_op = '0;
  logic [VA_W-1:0] cmd_va = '0;
  logic            wb_valid, wb_ref, wb_mod;

  tlb_xlate #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PB), .ENTRIES(2)) i_tlb_xlate (
    .clk, .rst_n, .req_valid, .req_store, .req_user, .req_va,
    .rsp_valid, .rsp_pa, .rsp_nocache, .rsp_exc, .busy,
    .walk_req, .walk_vpn, .walk_done, .walk_pfn, .walk_present,
    .walk_kernel, .walk_wprot, .walk_nocache,
    .cmd_valid, .cmd_op, .cmd_va, .wb_valid, .wb_vpn, .wb_ref, .wb_mod
  );

  // Page-table model: bit4 kernel, bit5 write-protect, bit6 no-cache, bit7 absent
  function automatic logic [PFNW-1:0] pfn_of(input logic [11:0] vpn);
    return {8'h00, vpn} ^ 20'hA5000;
  endfunction

  typedef struct packed {
    logic        is_cmd;
    logic        store;
    logic        user;
    logic [1:0]  op;
    logic [11:0] vpn;
    logic [11:0] ofs;
    logic        miss;
    logic [1:0]  exc;
    logic        wb;
    logic [11:0] wb_vpn;
    logic        wb_ref;
    logic        wb_mod;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b1,2'd0,12'h001,12'h123,1'b1,2'd0,1'b0,12'h000,1'b0,1'b0},
    '{1'b0,1'b1,1'b1,2'd0,12'h001,12'h456,1'b0,2'd0,1'b0,12'h000,1'b0,1'b0}, // R6 store hit
    '{1'b0,1'b0,1'b1,2'd0,12'h011,12'h010,1'b1,2'd2,1'b0,12'h000,1'b0,1'b0},
    '{1'b0,1'b0,1'b0,2'd0,12'h011,12'h020,1'b0,2'd0,1'b0,12'h000,1'b0,1'b0},
    '{1'b0,1'b1,1'b0,2'd0,12'h021,12'h030,1'b1,2'd3,1'b1,12'h001,1'b1,1'b1},
    '{1'b0,1'b0,1'b1,2'd0,12'h021,12'h040,1'b0,2'd0,1'b0,12'h000,1'b0,1'b0},
    '{1'b0,1'b0,1'b1,2'd0,12'h081,12'h050,1'b1,2'd1,1'b0,12'h000,1'b0,1'b0},
    '{1'b0,1'b0,1'b1,2'd0,12'h081,12'h060,1'b1,2'd1,1'b0,12'h000,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,2'd0,12'h011,12'h000,1'b0,2'd0,1'b0,12'h000,1'b0,1'b0},
    '{1'b0,1'b0,1'b1,2'd0,12'h041,12'h070,1'b1,2'd0,1'b0,12'h000,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,2'd2,12'h021,12'h000,1'b0,2'd0,1'b1,12'h021,1'b1,1'b0},
    '{1'b0,1'b0,1'b1,2'd0,12'h021,12'h080,1'b1,2'd0,1'b0,12'h000,1'b0,1'b0},
    '{1'b0,1'b1,1'b1,2'd0,12'h002,12'h090,1'b1,2'd0,1'b1,12'h041,1'b1,1'b0},
    '{1'b0,1'b1,1'b1,2'd0,12'h011,12'h0A0,1'b1,2'd2,1'b1,12'h021,1'b1,1'b0},
    '{1'b1,1'b0,1'b0,2'd3,12'h000,12'h000,1'b0,2'd0,1'b1,12'h002,1'b1,1'b1}, // R6 status
    '{1'b0,1'b0,1'b1,2'd0,12'h002,12'h0B0,1'b1,2'd0,1'b0,12'h000,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,2'd1,12'h000,12'h000,1'b0,2'd0,1'b0,12'h000,1'b0,1'b0},
    '{1'b0,1'b0,1'b1,2'd0,12'h002,12'h0C0,1'b1,2'd0,1'b0,12'h000,1'b0,1'b0},
    '{1'b0,1'b1,1'b1,2'd0,12'h0B1,12'h0D0,1'b1,2'd1,1'b0,12'h000,1'b0,1'b0}, // R5 fault first
    '{1'b0,1'b1,1'b1,2'd0,12'h031,12'h0E0,1'b1,2'd2,1'b0,12'h000,1'b0,1'b0}, // R5 priv over WP
    '{1'b0,1'b1,1'b0,2'd0,12'h031,12'h0F0,1'b0,2'd3,1'b0,12'h000,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,2'd2,12'h031,12'h000,1'b0,2'd0,1'b0,12'h000,1'b0,1'b0}  // R5 no status
  };

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic string exc_tag(input logic [1:0] e);
    case (e)
      2'd1:    return "R2 page fault";
      2'd2:    return "R3 privilege";
      2'd3:    return "R4 write protection";
      default: return "R1 no exception";
    endcase
  endfunction

  task automatic run_req(input vec_t v, input int n);
    logic got_miss;
    logic [PA_W-1:0] exp_pa;
    @(negedge clk);
    req_valid = 1; req_store = v.store; req_user = v.user;
    req_va = {24'h0, v.vpn, v.ofs};
    @(negedge clk);
    req_valid = 0;
    got_miss = walk_req;
    check($sformatf("R7 miss flag v%0d", n), got_miss, v.miss);
    if (got_miss) begin
      check($sformatf("R7 walk vpn v%0d", n), walk_vpn, {24'h0, v.vpn});
      walk_done    = 1;
      walk_pfn     = pfn_of(walk_vpn[11:0]);
      walk_present = !walk_vpn[7];
      walk_kernel  = walk_vpn[4];
      walk_wprot   = walk_vpn[5];
      walk_nocache = walk_vpn[6];
      @(negedge clk);
      walk_done = 0;
    end
    exp_pa = (v.exc == 2'd0) ? {pfn_of(v.vpn), v.ofs} : '0;
    check($sformatf("R1 rsp valid v%0d", n), rsp_valid, 1'b1);
    check($sformatf("%s v%0d", exc_tag(v.exc), n), rsp_exc, v.exc);
    check($sformatf("R1 pa v%0d", n), rsp_pa, exp_pa);
    check($sformatf("R1 nocache v%0d", n), rsp_nocache, (v.exc == 2'd0) & v.vpn[6]);
    check($sformatf("R8 wb strobe v%0d", n), wb_valid, v.wb);
    if (v.wb)
      check($sformatf("R8 wb data v%0d", n), {wb_vpn, wb_ref, wb_mod},
            {24'h0, v.wb_vpn, v.wb_ref, v.wb_mod});
  endtask

  task automatic run_cmd(input vec_t v, input int n);
    int nwb;
    logic [VPNW+1:0] last;
    string tag;
    tag = v.op[1] ? "R10 flush" : "R9 invalidate";
    nwb = 0; last = '0;
    @(negedge clk);
    cmd_valid = 1; cmd_op = v.op; cmd_va = {24'h0, v.vpn, 12'h000};
    @(negedge clk);
    cmd_valid = 0;
    forever begin
      if (wb_valid) begin nwb++; last = {wb_vpn, wb_ref, wb_mod}; end
      if (!busy) break;
      @(negedge clk);
    end
    check($sformatf("%s wb count v%0d", tag, n), nwb, {63'h0, v.wb});
    if (v.wb)
      check($sformatf("%s wb data v%0d", tag, n), last, {24'h0, v.wb_vpn, v.wb_ref, v.wb_mod});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    check("R12 rsp_valid", rsp_valid, 0);
    check("R12 walk_req", walk_req, 0);
    check("R12 wb_valid", wb_valid, 0);
    check("R12 busy", busy, 0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].is_cmd) run_cmd(VECS[i], i);
      else                run_req(VECS[i], i);
    end

    // R11: command beats a same-cycle request; requests while busy are dropped
    @(negedge clk);
    cmd_valid = 1; cmd_op = 2'd1; cmd_va = '0;
    req_valid = 1; req_store = 0; req_user = 1; req_va = {24'h0, 12'h002, 12'h111};
    @(negedge clk);
    cmd_valid = 0;
    forever begin
      check("R11 no rsp while busy", rsp_valid, 0);
      check("R11 no walk while busy", walk_req, 0);
      check("R9 silent global invalidate", wb_valid, 0);
      if (!busy) break;
      @(negedge clk);
    end
    req_valid = 0;
    @(negedge clk);
    check("R11 dropped request gave no rsp", rsp_valid, 0);
    // Page 0x002 was cached; it must now miss (command won, entry discarded)
    run_req('{1'b0,1'b0,1'b1,2'd0,12'h002,12'h111,1'b1,2'd0,1'b0,12'h000,1'b0,1'b0}, 99);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule